// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready and Threshold Flags

A one-way buffer for 36-bit words that joins two clock domains. The clocks may be unrelated or the same. The producer writes on its own clock. It sees an input-ready flag and an active-low almost-full flag, both registered on that clock. The consumer reads on a second clock. The head word already sits in an output register, so a valid word is on `rd_data` whenever output-ready is high. That side also has an active-low almost-empty flag. Both the write and read pointers cross between domains as Gray code through two flip-flops.

The two threshold offsets, X for almost-empty and Y for almost-full, are fixed at reset. A 2-bit select input is held steady while reset is released. A non-zero code applies one preset value to both offsets. Code zero instead lets the first two writes after reset load X and then Y. The FIFO accepts data only after both are loaded.

Top module: `xclk_flag_fifo`

## Requirements
- R1: While `rst_n` is low, `in_rdy` and `out_rdy` are low. With a preset code selected, `in_rdy` is low after the first write-clock rising edge following release and high after the second.
- R2: When a word is written into an empty FIFO, `out_rdy` is still low after the second read-clock rising edge that follows the write edge. It is high after the third, with that word on `rd_data`.
- R3: Words leave in the order they were written. While `out_rdy` is high and no read is taken, `rd_data` and `out_rdy` hold.
- R4: The FIFO holds DEPTH words in its array plus one in the output register. Once that many are stored, `in_rdy` is low and further write attempts store nothing.
- R5: A read attempt while `out_rdy` is low has no effect on the stored words.
- R6: `ae_n` is low when the stored word count (array plus output register) is less than or equal to X, and high otherwise. It is timed to the read clock.
- R7: `af_n` is low when the free array locations (DEPTH minus words in the array, not counting the output register) number Y or fewer, and high otherwise. It is timed to the write clock.
- R8: `ofs_sel` value 2'b01 sets X = Y = 8, 2'b10 sets X = Y = 16, and 2'b11 sets X = Y = 64.
- R9: With `ofs_sel` = 2'b00, the first write after reset loads X and the second loads Y, each from `wr_data[AW:0]`. Neither word is stored. `in_rdy` rises on the write edge after the one that loaded Y.
- R10: A write is taken only when `wr_csn` is low, `wr_en` is high and `in_rdy` is high. A read is taken only when `rd_csn` is low, `rd_en` is high and `out_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, seen by both clocks |
| ofs_sel | input | 2 | Offset mode select, sampled while reset is released |
| wr_csn | input | 1 | Write-side chip select, active low |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Write data, or offset value in load mode |
| in_rdy | output | 1 | Space available / write accepted |
| af_n | output | 1 | Almost-full, active low |
| rd_csn | input | 1 | Read-side chip select, active low |
| rd_en | input | 1 | Read enable |
| rd_data | output | 36 | Output register contents |
| out_rdy | output | 1 | Valid word present on `rd_data` |
| ae_n | output | 1 | Almost-empty, active low |

## Verification
The bench builds the block with the default DEPTH of 256 and clock periods that never share an edge. The read-side latency counts are therefore exact. At this depth a full fill of 257 words and the 248/249-word almost-full boundary for offset 8 both fit in a short run. The 192/193-word boundary for offset 64 also fits. All three preset codes and the load mode are each brought up from a fresh reset.

// File: rtl/xff_pkg.sv
package xff_pkg;
    localparam int WORD_W = 36;

    typedef enum logic [1:0] {
        OFS_LOAD = 2'b00,
        OFS_P8   = 2'b01,
        OFS_P16  = 2'b10,
        OFS_P64  = 2'b11
    } ofs_mode_e;

    function automatic int preset_offset(input logic [1:0] code);
        case (ofs_mode_e'(code))
            OFS_P8:  return 8;
            OFS_P16: return 16;
            OFS_P64: return 64;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/xff_mem.sv
module xff_mem #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/xff_gray_sync.sv
module xff_gray_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n)      stg_d[i] = '0;
            else if (i == 0) stg_d[i] = gray_in;
            else             stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end

    always_comb begin
        bin_out[W-1] = stg_q[STAGES-1][W-1];
        for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ stg_q[STAGES-1][i];
    end
endmodule

// File: rtl/xff_wr_side.sv
module xff_wr_side #(
    parameter int AW = 8
) (
    input  logic        wr_clk,
    input  logic        rst_n,
    input  logic [1:0]  ofs_sel,
    input  logic        wr_csn,
    input  logic        wr_en,
    input  logic [AW:0] wr_low,
    input  logic [AW:0] rd_bin_sync,
    output logic        mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0] wr_gray,
    output logic [AW:0] wr_ptr,
    output logic [AW:0] x_ofs,
    output logic        cfg_done,
    output logic        in_rdy,
    output logic        af_n
);
    import xff_pkg::*;

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [1:0]    sel;
        logic          cfg;
        logic          got_x;
        logic [PW-1:0] x;
        logic [PW-1:0] y;
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          rdy;
        logic          afn;
    } wst_t;

    wst_t s_q, s_d;
    logic access, fire;
    logic [PW-1:0] used, free;

    always_comb begin
        s_d    = s_q;
        access = !wr_csn && wr_en;
        fire   = access && s_q.cfg && s_q.rdy;
        used   = '0;
        free   = '0;
        if (!rst_n) begin
            s_d       = '0;
            s_d.sel   = ofs_sel;
            s_d.afn   = 1'b1;
        end else begin
            if (!s_q.cfg) begin
                if (s_q.sel != OFS_LOAD) begin
                    s_d.x   = PW'(preset_offset(s_q.sel));
                    s_d.y   = PW'(preset_offset(s_q.sel));
                    s_d.cfg = 1'b1;
                end else if (access) begin
                    if (!s_q.got_x) begin
                        s_d.x     = wr_low;
                        s_d.got_x = 1'b1;
                    end else begin
                        s_d.y   = wr_low;
                        s_d.cfg = 1'b1;
                    end
                end
            end
            s_d.ptr  = s_q.ptr + PW'(fire);
            s_d.gray = s_d.ptr ^ (s_d.ptr >> 1);
            used     = s_d.ptr - rd_bin_sync;
            free     = PW'(DEPTH) - used;
            s_d.rdy  = s_q.cfg && (used != PW'(DEPTH));
            s_d.afn  = s_q.cfg ? (free > s_q.y) : 1'b1;
        end
    end

    always_ff @(posedge wr_clk) s_q <= s_d;

    assign mem_we    = fire;
    assign mem_waddr = s_q.ptr[AW-1:0];
    assign wr_gray   = s_q.gray;
    assign wr_ptr    = s_q.ptr;
    assign x_ofs     = s_q.x;
    assign cfg_done  = s_q.cfg;
    assign in_rdy    = s_q.rdy;
    assign af_n      = s_q.afn;
endmodule

// File: rtl/xff_rd_side.sv
module xff_rd_side #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_csn,
    input  logic          rd_en,
    input  logic [AW:0]   wr_bin_sync,
    input  logic [AW:0]   x_ofs,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rd_gray,
    output logic [DW-1:0] rd_data,
    output logic          out_rdy,
    output logic          ae_n
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [DW-1:0] dout;
        logic          ov;
        logic          aen;
    } rst_t;

    rst_t s_q, s_d;
    logic take, mem_ne, load;
    logic [PW:0] cnt;

    always_comb begin
        s_d    = s_q;
        take   = !rd_csn && rd_en && s_q.ov;
        mem_ne = s_q.ptr != wr_bin_sync;
        load   = mem_ne && (!s_q.ov || take);
        cnt    = '0;
        if (!rst_n) begin
            s_d = '0;
        end else begin
            if (load) begin
                s_d.dout = mem_rdata;
                s_d.ov   = 1'b1;
                s_d.ptr  = s_q.ptr + PW'(1);
            end else if (take) begin
                s_d.ov = 1'b0;
            end
            s_d.gray = s_d.ptr ^ (s_d.ptr >> 1);
            cnt      = {1'b0, wr_bin_sync - s_d.ptr} + (PW+1)'(s_d.ov);
            s_d.aen  = cnt > {1'b0, x_ofs};
        end
    end

    always_ff @(posedge rd_clk) s_q <= s_d;

    assign mem_raddr = s_q.ptr[AW-1:0];
    assign rd_gray   = s_q.gray;
    assign rd_data   = s_q.dout;
    assign out_rdy   = s_q.ov;
    assign ae_n      = s_q.aen;
endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo #(
    parameter int DEPTH = 256
) (
    input  logic        wr_clk,
    input  logic        rd_clk,
    input  logic        rst_n,
    input  logic [1:0]  ofs_sel,
    input  logic        wr_csn,
    input  logic        wr_en,
    input  logic [35:0] wr_data,
    output logic        in_rdy,
    output logic        af_n,
    input  logic        rd_csn,
    input  logic        rd_en,
    output logic [35:0] rd_data,
    output logic        out_rdy,
    output logic        ae_n
);
    import xff_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic [WORD_W-1:0] mem_rdata;
    logic [PW-1:0]     wr_gray, rd_gray, wr_ptr, x_ofs;
    logic [PW-1:0]     wr_bin_at_rd, rd_bin_at_wr;
    logic              wr_cfg;

    xff_wr_side #(.AW(AW)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_csn(wr_csn), .wr_en(wr_en), .wr_low(wr_data[AW:0]),
        .rd_bin_sync(rd_bin_at_wr), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .wr_gray(wr_gray), .wr_ptr(wr_ptr), .x_ofs(x_ofs), .cfg_done(wr_cfg),
        .in_rdy(in_rdy), .af_n(af_n)
    );

    xff_mem #(.AW(AW), .DW(WORD_W)) u_mem (
        .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    xff_gray_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wr_gray), .bin_out(wr_bin_at_rd)
    );

    xff_gray_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rd_gray), .bin_out(rd_bin_at_wr)
    );

    xff_rd_side #(.AW(AW), .DW(WORD_W)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_csn(rd_csn), .rd_en(rd_en),
        .wr_bin_sync(wr_bin_at_rd), .x_ofs(x_ofs), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .rd_gray(rd_gray), .rd_data(rd_data),
        .out_rdy(out_rdy), .ae_n(ae_n)
    );
endmodule

// File: rtl/xclk_flag_fifo_chk.sv
module xclk_flag_fifo_chk #(
    parameter int PW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          in_rdy,
    input logic          af_n,
    input logic          out_rdy,
    input logic          ae_n,
    input logic          rd_csn,
    input logic          rd_en,
    input logic [35:0]   rd_data,
    input logic          cfg_done,
    input logic [PW-1:0] wr_ptr
);
    p_no_write_when_full_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (cfg_done && !in_rdy) |=> $stable(wr_ptr));

    p_rdy_after_cfg_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(in_rdy) |-> $past(cfg_done));

    p_full_is_almost_full_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (cfg_done && $past(cfg_done) && !in_rdy) |-> !af_n);

    p_empty_no_change_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !out_rdy |=> (out_rdy || $stable(rd_data)));

    p_head_holds_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (out_rdy && !(!rd_csn && rd_en)) |=> (out_rdy && $stable(rd_data)));

    p_empty_is_almost_empty_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !out_rdy |-> !ae_n);
endmodule

bind xclk_flag_fifo xclk_flag_fifo_chk #(.PW(AW + 1)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .in_rdy(in_rdy),
    .af_n(af_n), .out_rdy(out_rdy), .ae_n(ae_n), .rd_csn(rd_csn),
    .rd_en(rd_en), .rd_data(rd_data), .cfg_done(wr_cfg), .wr_ptr(wr_ptr)
);

// File: tb/xclk_flag_fifo_tb.sv
`timescale 1ns/100ps
module xclk_flag_fifo_tb;
    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;
    localparam int DEPTH     = 256;
    localparam logic [35:0] BASE = 36'hA_5000_0000;

    logic wr_clk = 0, rd_clk = 0, rst_n = 0;
    logic [1:0] ofs_sel = 2'b01;
    logic wr_csn = 1, wr_en = 0, rd_csn = 1, rd_en = 0;
    logic [35:0] wr_data = '0;
    logic in_rdy, af_n, out_rdy, ae_n;
    logic [35:0] rd_data;

    int n_run = 0, n_fail = 0;
    int wr_idx = 0, rd_idx = 0;
    bit finished = 0;

    initial forever #(WR_PERIOD / 2) wr_clk = ~wr_clk;
    initial begin
        #2.5;
        forever #(RD_PERIOD / 2) rd_clk = ~rd_clk;
    end

    xclk_flag_fifo #(.DEPTH(DEPTH)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_csn(wr_csn), .wr_en(wr_en), .wr_data(wr_data), .in_rdy(in_rdy),
        .af_n(af_n), .rd_csn(rd_csn), .rd_en(rd_en), .rd_data(rd_data),
        .out_rdy(out_rdy), .ae_n(ae_n)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        rst_n = 0; ofs_sel = sel;
        wr_csn = 1; wr_en = 0; rd_csn = 1; rd_en = 0;
        wr_idx = 0; rd_idx = 0;
        repeat (6) @(posedge rd_clk);
        #1;
        chk("R1 in_rdy in reset", in_rdy, 0);
        chk("R1 out_rdy in reset", out_rdy, 0);
        @(negedge wr_clk) rst_n = 1;
    endtask

    task automatic wr_raw(input logic [35:0] d, input logic cs_n, input logic en);
        @(negedge wr_clk);
        wr_csn = cs_n; wr_en = en; wr_data = d;
        @(posedge wr_clk);
        #1;
        wr_csn = 1; wr_en = 0;
    endtask

    task automatic wr_next();
        wr_raw(BASE + 36'(wr_idx), 0, 1);
        wr_idx++;
    endtask

    task automatic rd_next(input string req);
        @(negedge rd_clk);
        chk({req, " out_rdy"}, out_rdy, 1);
        chk({req, " data"}, rd_data, BASE + 36'(rd_idx));
        rd_csn = 0; rd_en = 1;
        @(posedge rd_clk);
        #1;
        rd_csn = 1; rd_en = 0;
        rd_idx++;
    endtask

    task automatic settle();
        repeat (8) @(posedge rd_clk);
        #1;
    endtask

    task automatic t_preset8_fill();
        do_reset(2'b01);
        @(posedge wr_clk); #1;
        chk("R1 in_rdy after edge 1", in_rdy, 0);
        @(posedge wr_clk); #1;
        chk("R1 in_rdy after edge 2", in_rdy, 1);
        repeat (8) wr_next();
        settle();
        chk("R6 ae_n at 8 words", ae_n, 0);
        wr_next();
        settle();
        chk("R6 ae_n at 9 words", ae_n, 1);
        while (wr_idx < 248) wr_next();
        settle();
        chk("R7 af_n at 248 written", af_n, 1);
        wr_next();
        settle();
        chk("R7 af_n at 249 written", af_n, 0);
        for (int g = 0; g < 20; g++) begin
            @(negedge wr_clk);
            if (in_rdy) wr_next();
        end
        chk("R4 words accepted", 64'(wr_idx), 64'(DEPTH + 1));
        chk("R4 in_rdy when full", in_rdy, 0);
        wr_raw(36'hF_FFFF_FFFF, 0, 1);
        settle();
        chk("R4 in_rdy after extra write", in_rdy, 0);
        while (rd_idx < DEPTH + 1) rd_next("R3 drain");
        settle();
        chk("R4 out_rdy after drain", out_rdy, 0);
        chk("R6 ae_n empty", ae_n, 0);
    endtask

    task automatic t_empty_and_latency();
        @(negedge rd_clk);
        rd_csn = 0; rd_en = 1;
        @(posedge rd_clk); #1;
        rd_csn = 1; rd_en = 0;
        chk("R5 out_rdy after read on empty", out_rdy, 0);
        @(negedge wr_clk);
        wr_csn = 0; wr_en = 1; wr_data = BASE + 36'(wr_idx);
        @(posedge wr_clk);
        #0.2;
        wr_csn = 1; wr_en = 0; wr_idx++;
        @(posedge rd_clk);
        @(posedge rd_clk); #1;
        chk("R2 out_rdy after 2 read edges", out_rdy, 0);
        @(posedge rd_clk); #1;
        chk("R2 out_rdy after 3 read edges", out_rdy, 1);
        chk("R2 R5 word present", rd_data, BASE + 36'(rd_idx));
    endtask

    task automatic t_gating();
        wr_raw(36'h1_2345_6789, 1, 1);
        wr_raw(36'h1_2345_6789, 0, 0);
        @(negedge rd_clk);
        rd_csn = 0; rd_en = 0;
        @(posedge rd_clk); #1;
        rd_csn = 1; rd_en = 1;
        @(posedge rd_clk); #1;
        rd_en = 0;
        chk("R10 R3 head held without take", rd_data, BASE + 36'(rd_idx));
        chk("R10 out_rdy held", out_rdy, 1);
        rd_next("R10 single word");
        settle();
        chk("R10 no gated write stored", out_rdy, 0);
    endtask

    task automatic t_preset16();
        do_reset(2'b10);
        repeat (3) @(posedge wr_clk);
        repeat (16) wr_next();
        settle();
        chk("R8 code 10 ae_n at 16", ae_n, 0);
        wr_next();
        settle();
        chk("R8 code 10 ae_n at 17", ae_n, 1);
    endtask

    task automatic t_preset64();
        do_reset(2'b11);
        repeat (3) @(posedge wr_clk);
        repeat (64) wr_next();
        settle();
        chk("R8 code 11 ae_n at 64", ae_n, 0);
        wr_next();
        settle();
        chk("R8 code 11 ae_n at 65", ae_n, 1);
        while (wr_idx < 192) wr_next();
        settle();
        chk("R8 code 11 af_n at 192", af_n, 1);
        wr_next();
        settle();
        chk("R8 code 11 af_n at 193", af_n, 0);
    endtask

    task automatic t_load_mode();
        do_reset(2'b00);
        repeat (3) @(posedge wr_clk);
        #1;
        chk("R9 in_rdy before loads", in_rdy, 0);
        wr_raw(36'd3, 0, 1);
        chk("R9 in_rdy after X load", in_rdy, 0);
        wr_raw(36'd5, 0, 1);
        chk("R9 in_rdy at Y load edge", in_rdy, 0);
        @(posedge wr_clk); #1;
        chk("R9 in_rdy edge after Y load", in_rdy, 1);
        repeat (3) wr_next();
        settle();
        chk("R9 ae_n at 3 words (X=3)", ae_n, 0);
        wr_next();
        settle();
        chk("R9 ae_n at 4 words", ae_n, 1);
        rd_next("R9 config words not stored");
    endtask

    initial begin
        #(200000 * WR_PERIOD);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_preset8_fill();
        t_empty_and_latency();
        t_gating();
        t_preset16();
        t_preset64();
        t_load_mode();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule